// File: doc/BRIEF.md
# Phase-Accumulator Frequency Synthesizer

The block generates an approximate clock at a target frequency from a faster
accumulator clock. A phase register grows by a constant step on every enabled
cycle and wraps at its own width; its most significant bit is the synthesized
output. Both the register width and the step are worked out while the design
elaborates, from three parameters: the accumulator clock frequency, the target
frequency and a relative tolerance given in parts per million.

A tighter tolerance produces a wider phase register. Each output edge lands on
an accumulator clock edge, so it can be up to one accumulator period early or
late. The average frequency still stays within the tolerance. A parameter set
whose target is not below half the accumulator frequency stops elaboration with
an error.

Top module: `dds_synth`

## Requirements
- R1: A synchronous reset clears the phase register to zero, so `clk_out` is low in the cycle after any reset edge. This holds for the first reset and for a reset in the middle of a run.
- R2: On every enabled cycle the phase register adds the step INC and wraps modulo 2^W.
- R3: `clk_out` is a registered copy of bit W-1 of the phase register.
- R4: The width W is the smallest integer with 2^W >= F_ACC_HZ / (F_TGT_HZ * TOL_PPM * 1e-6). For the defaults (200 MHz, 78 MHz, 100 ppm) this gives W = 15.
- R5: The step INC is F_TGT_HZ * 2^W / F_ACC_HZ rounded to the nearest integer, with halves rounding up. For the defaults this gives 12780. Over 2^W enabled cycles counted from zero phase, `clk_out` shows exactly INC rising edges.
- R6: The average output frequency, INC * F_ACC_HZ / 2^W, differs from F_TGT_HZ by no more than F_TGT_HZ * TOL_PPM * 1e-6.
- R7: With `en` held high, the spacing between consecutive rising edges of `clk_out` is always floor(2^W/INC) or ceil(2^W/INC) cycles.
- R8: While `en` is low the phase register holds its value and `clk_out` does not change. When `en` returns high, the sequence continues from the held phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Accumulator clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the phase |
| clk_out | output | 1 | Synthesized clock (registered MSB of phase) |

## Verification
The first pattern is a continuous run with `en` held high for a full 2^W cycles starting from zero phase. Its rising-edge count pins down both the width and the rounded step, because a wrong W or an off-by-one step changes the count. The same run measures edge spacing, which separates correct one-cycle jitter from a broken wrap. The second pattern is a randomly gated `en`, compared cycle by cycle with a bench model. It shows whether a frozen cycle truly holds the phase or skips a step. A reset inserted mid-run tells a synchronous clear apart from one that leaves stale phase behind.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Smallest w with 2^w >= ceil(f_acc / (f_tgt * tol_ppm * 1e-6))
  function automatic int calc_width(longint f_acc, longint f_tgt, longint tol_ppm);
    longint num;
    longint den;
    longint q;
    longint p;
    int w;
    num = f_acc * 64'd1_000_000;
    den = f_tgt * tol_ppm;
    q   = (num + den - 1) / den;
    p   = 1;
    w   = 0;
    while (p < q) begin
      p = p * 2;
      w = w + 1;
    end
    return w;
  endfunction

  // Round-to-nearest of f_tgt * 2^w / f_acc
  function automatic longint calc_step(longint f_acc, longint f_tgt, int w);
    return ((f_tgt << w) + (f_acc / 2)) / f_acc;
  endfunction

endpackage

// File: rtl/dds_param_guard.sv
module dds_param_guard #(
  parameter longint F_ACC_HZ = 200_000_000,
  parameter longint F_TGT_HZ = 78_000_000,
  parameter longint TOL_PPM  = 100
) ();
  generate
    if (2 * F_TGT_HZ >= F_ACC_HZ) begin : g_bad_ratio
      $error("dds_param_guard: target frequency must be below half the accumulator clock");
    end
    if (TOL_PPM <= 0 || F_TGT_HZ <= 0) begin : g_bad_tol
      $error("dds_param_guard: tolerance and target frequency must be positive");
    end
  endgenerate
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int            PW  = 15,
  parameter logic [PW-1:0] INC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nxt
);

  always_comb begin
    phase_nxt = phase_q + INC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (en) begin
      phase_q <= phase_nxt;
    end
  end

  // R1: phase starts from zero after any reset cycle
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (phase_q == '0));

  // R2: an enabled cycle advances by the step, wrapping at the width
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en)) |-> (phase_q == PW'($past(phase_q) + INC)));

  // R8: a disabled cycle leaves the phase untouched
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(phase_q));

endmodule

// File: rtl/dds_msb_tap.sv
module dds_msb_tap #(
  parameter int PW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] phase_nxt,
  output logic          out_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else if (en) begin
      out_q <= phase_nxt[PW-1];
    end
  end

  // R8: output cannot move on a disabled cycle
  p_no_toggle_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(out_q));

  // R1: output low right after reset
  p_out_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_q);

endmodule

// File: rtl/dds_synth.sv
module dds_synth #(
  parameter longint F_ACC_HZ = 200_000_000,
  parameter longint F_TGT_HZ = 78_000_000,
  parameter longint TOL_PPM  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic clk_out
);
  import dds_pkg::*;

  localparam int            PW     = calc_width(F_ACC_HZ, F_TGT_HZ, TOL_PPM);
  localparam longint        STEP_L = calc_step(F_ACC_HZ, F_TGT_HZ, PW);
  localparam logic [PW-1:0] INC    = STEP_L[PW-1:0];

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;

  dds_param_guard #(
    .F_ACC_HZ (F_ACC_HZ),
    .F_TGT_HZ (F_TGT_HZ),
    .TOL_PPM  (TOL_PPM)
  ) guard_i ();

  dds_phase_acc #(
    .PW  (PW),
    .INC (INC)
  ) acc_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt)
  );

  dds_msb_tap #(
    .PW (PW)
  ) tap_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .phase_nxt (phase_nxt),
    .out_q     (clk_out)
  );

  // R3: tap register tracks the accumulator MSB
  p_msb_match_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (clk_out == phase_q[PW-1]));

endmodule

// File: tb/dds_synth_tb_top.sv
`timescale 1ns/1ps
module dds_synth_tb_top;

  localparam longint F_ACC = 200_000_000;
  localparam longint F_TGT = 78_000_000;
  localparam longint TOL   = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic clk_out;

  int total = 0;
  int bad   = 0;

  int     w_exp;
  longint inc_exp;
  longint modv;
  longint ph;
  longint cyc;
  longint last_rise;
  longint rises;
  int     gap_lo;
  int     gap_hi;
  bit     prev_out;
  bit     track_gaps;

  always #10 clk = ~clk;

  dds_synth #(.F_ACC_HZ(F_ACC), .F_TGT_HZ(F_TGT), .TOL_PPM(TOL)) dut_i (
    .clk(clk), .rst(rst), .en(en), .clk_out(clk_out)
  );

  function automatic int exp_width();
    real x;
    x = real'(F_ACC) / (real'(F_TGT) * real'(TOL) * 1.0e-6);
    return int'($ceil($ln(x) / $ln(2.0) - 1.0e-12));
  endfunction

  function automatic longint exp_inc(int w);
    real v;
    v = real'(F_TGT) * (2.0 ** w) / real'(F_ACC);
    return longint'($floor(v + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input bit r, input bit e);
    bit msb;
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) ph = 0;
    else if (e) ph = (ph + inc_exp) % modv;
    @(negedge clk);
    cyc++;
    msb = ((ph >> (w_exp - 1)) & 1) != 0;
    check(clk_out == msb, "R2 R3 R8 phase model", longint'(clk_out), longint'(msb));
    if (track_gaps && clk_out && !prev_out) begin
      rises++;
      if (last_rise >= 0)
        check((cyc - last_rise) == gap_lo || (cyc - last_rise) == gap_hi,
              "R7 edge spacing", cyc - last_rise, gap_lo);
      last_rise = cyc;
    end
    prev_out = clk_out;
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    real favg;
    void'($urandom(32'd1234));
    w_exp   = exp_width();
    inc_exp = exp_inc(w_exp);
    modv    = 64'd1 << w_exp;
    gap_lo  = int'(modv / inc_exp);
    gap_hi  = (modv % inc_exp == 0) ? gap_lo : gap_lo + 1;
    ph = 0; cyc = 0; rises = 0; last_rise = -1; prev_out = 0; track_gaps = 0;

    // R4 / R5: bench-side derivation of the defaults
    check(w_exp == 15, "R4 width", w_exp, 15);
    check(inc_exp == 12780, "R5 step rounding", inc_exp, 12780);

    // R1: initial reset
    repeat (3) step(1'b1, 1'b0);
    check(clk_out == 1'b0, "R1 reset state", longint'(clk_out), 0);

    // Continuous full period from zero phase
    track_gaps = 1;
    for (int i = 0; i < int'(modv); i++) step(1'b0, 1'b1);
    track_gaps = 0;
    check(rises == inc_exp, "R4 R5 rising edges per 2^W cycles", rises, inc_exp);
    favg = real'(rises) * real'(F_ACC) / real'(modv);
    check((favg - real'(F_TGT) <= real'(F_TGT) * real'(TOL) * 1.0e-6) &&
          (real'(F_TGT) - favg <= real'(F_TGT) * real'(TOL) * 1.0e-6),
          "R6 average frequency", longint'(favg), F_TGT);

    // R8: directed hold while output is high, then random gating
    while (clk_out != 1'b1) step(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b0);
      check(clk_out == 1'b1, "R8 hold keeps output", longint'(clk_out), 1);
    end
    for (int i = 0; i < 3000; i++) step(1'b0, ($urandom % 3) != 0);

    // R1: mid-run synchronous reset
    while (clk_out != 1'b1) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check(clk_out == 1'b0, "R1 mid-run reset clears", longint'(clk_out), 0);
    for (int i = 0; i < 300; i++) step(1'b0, ($urandom % 4) != 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule